// File: doc/BRIEF.md
# Received Code Change Detector

This block watches three incoming code channels and reports when any of them changes. The channels are a 4-bit S/Q code, a 4-bit command/indicate code on channel 0, and a 6-bit command/indicate code on channel 1. Each channel has its own valid strobe. A valid code is compared with the code most recently captured on that channel, and a code that differs is captured.

The visible code register of a channel is not overwritten while software has not yet read it. A later code waits in a single holding slot, and each newer change overwrites that slot. Reading the channel then moves the waiting code into the visible register at once. A status word carries one change flag per channel. A one-cycle pulse tells the interrupt controller that a reported flag has been raised.

The S/Q and channel 1 flags are reported only while their enables are set. The channel 1 flag also needs terminal mode. A masked change is still captured, and it is reported as soon as its gate opens.

Top module: `code_change_detect`

## Requirements
- R1: During reset and after it, every visible code register holds all-ones, the status word is zero and changeIrq is low.
- R2: A valid code that differs from the last captured code on a channel with no unread value appears in that channel's code register one cycle later. In the same cycle the channel's status bit rises (bit 0 S/Q, bit 1 channel 0, bit 2 channel 1) and changeIrq pulses high for exactly one cycle.
- R3: A valid code equal to the last captured code is ignored: no register, flag or pulse changes.
- R4: While a channel's visible register is unread, a further change leaves the visible register unchanged.
- R5: A read of a channel that has a waiting code loads that code into the visible register in the next cycle, sets the channel's flag again and pulses changeIrq.
- R6: Among several changes made while the register is unread, only the newest is kept. Intermediate codes are never shown, and a change is detected against the waiting code when one exists.
- R7: A status read clears the reported flags after the cycle. A flag raised by a load in the same cycle stays set.
- R8: While the S/Q enable is low, an S/Q change is still captured, but its flag reads zero and no pulse is raised. Setting the enable then shows the flag and pulses changeIrq.
- R9: The channel 1 flag is reported and pulsed only while both terminalMode and the channel 1 enable are high. The code is captured regardless.
- R10: A channel read with no waiting code marks the register as read, so the next change loads directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sqValid | input | 1 | S/Q code strobe |
| sqCode | input | 4 | Incoming S/Q code |
| ci0Valid | input | 1 | Channel 0 code strobe |
| ci0Code | input | 4 | Incoming channel 0 code |
| ci1Valid | input | 1 | Channel 1 code strobe |
| ci1Code | input | 6 | Incoming channel 1 code |
| sqEnable | input | 1 | Reports the S/Q flag when high |
| ci1Enable | input | 1 | Reports the channel 1 flag when high (with terminalMode) |
| terminalMode | input | 1 | Terminal mode; needed for channel 1 reporting |
| statusRd | input | 1 | Status word read strobe, clears reported flags |
| sqRd | input | 1 | S/Q code register read strobe |
| ci0Rd | input | 1 | Channel 0 code register read strobe |
| ci1Rd | input | 1 | Channel 1 code register read strobe |
| status | output | 3 | Reported change flags: bit 0 S/Q, bit 1 ch0, bit 2 ch1 |
| sqReg | output | 4 | Visible S/Q code |
| ci0Reg | output | 4 | Visible channel 0 code |
| ci1Reg | output | 6 | Visible channel 1 code |
| changeIrq | output | 1 | One-cycle change pulse to the interrupt controller |

## Verification
The hardest state to reach from the ports is a promotion on read, where a waiting code has already been overwritten by several later changes. The stimulus first loads a code and never reads it. It then sends a run of distinct codes, and the visible register must stay frozen throughout. Two channel reads follow: the first must show only the newest code together with a fresh flag and pulse, and the second must leave the register untouched so that the next change loads directly. A status read in the same cycle as a load, and gates that open on a flag already pending, are each set up by ordering the strobes so that the two events land on the same edge.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
  localparam int NUM_CH = 3;
  localparam int CH_SQ  = 0;
  localparam int CH_CI0 = 1;
  localparam int CH_CI1 = 2;

  typedef struct packed {
    logic [NUM_CH-1:0] loadIn;     // incoming code goes straight to visible register
    logic [NUM_CH-1:0] promote;    // waiting code moves to visible register
    logic [NUM_CH-1:0] pendWrite;  // incoming code goes to holding slot
  } ccdStrobes_t;
endpackage

// File: rtl/ccd_chan_buf.sv
module ccd_chan_buf #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] inCode,
  input  logic         loadIn,
  input  logic         promote,
  input  logic         pendWrite,
  output logic [W-1:0] visCode,
  output logic         diffVis,
  output logic         diffPend
);
  logic [W-1:0] pendCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      visCode  <= '1;
      pendCode <= '1;
    end else begin
      if (promote)      visCode <= pendCode;
      else if (loadIn)  visCode <= inCode;
      if (pendWrite)    pendCode <= inCode;
    end
  end

  assign diffVis  = (inCode != visCode);
  assign diffPend = (inCode != pendCode);
endmodule

// File: rtl/ccd_ctrl.sv
module ccd_ctrl
  import ccd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] valid,
  input  logic [NUM_CH-1:0] diffVis,
  input  logic [NUM_CH-1:0] diffPend,
  input  logic [NUM_CH-1:0] codeRd,
  input  logic [NUM_CH-1:0] gate,
  input  logic              statusRd,
  output ccdStrobes_t       strb,
  output logic [NUM_CH-1:0] status,
  output logic              changeIrq,
  output logic [NUM_CH-1:0] pendValid,
  output logic [NUM_CH-1:0] unread
);
  logic [NUM_CH-1:0] newDiff, unreadAfter, loadEvt, rawFlag, gatePrev;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign newDiff[i]      = valid[i] & (pendValid[i] ? diffPend[i] : diffVis[i]);
    assign unreadAfter[i]  = pendValid[i] | (unread[i] & ~codeRd[i]);
    assign strb.promote[i] = codeRd[i] & pendValid[i];
    assign strb.loadIn[i]  = newDiff[i] & ~unreadAfter[i];
    assign strb.pendWrite[i] = newDiff[i] & unreadAfter[i];
  end

  assign loadEvt = strb.promote | strb.loadIn;
  assign status  = rawFlag & gate;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unread    <= '0;
      pendValid <= '0;
      rawFlag   <= '0;
      gatePrev  <= '0;
      changeIrq <= 1'b0;
    end else begin
      unread    <= loadEvt | (unread & ~codeRd);
      pendValid <= strb.pendWrite | (pendValid & ~strb.promote);
      rawFlag   <= (rawFlag & ~({NUM_CH{statusRd}} & gate)) | loadEvt;
      gatePrev  <= gate;
      changeIrq <= |(gate & (loadEvt | (rawFlag & ~gatePrev)));
    end
  end
endmodule

// File: rtl/code_change_detect.sv
module code_change_detect
  import ccd_pkg::*;
#(
  parameter int SQ_W  = 4,
  parameter int CI0_W = 4,
  parameter int CI1_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sqValid,
  input  logic [SQ_W-1:0]  sqCode,
  input  logic             ci0Valid,
  input  logic [CI0_W-1:0] ci0Code,
  input  logic             ci1Valid,
  input  logic [CI1_W-1:0] ci1Code,
  input  logic             sqEnable,
  input  logic             ci1Enable,
  input  logic             terminalMode,
  input  logic             statusRd,
  input  logic             sqRd,
  input  logic             ci0Rd,
  input  logic             ci1Rd,
  output logic [NUM_CH-1:0] status,
  output logic [SQ_W-1:0]  sqReg,
  output logic [CI0_W-1:0] ci0Reg,
  output logic [CI1_W-1:0] ci1Reg,
  output logic             changeIrq
);
  ccdStrobes_t       strb;
  logic [NUM_CH-1:0] diffVis, diffPend, gate, pendValid, unread;

  assign gate[CH_SQ]  = sqEnable;
  assign gate[CH_CI0] = 1'b1;
  assign gate[CH_CI1] = ci1Enable & terminalMode;

  ccd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .valid({ci1Valid, ci0Valid, sqValid}),
    .diffVis(diffVis), .diffPend(diffPend),
    .codeRd({ci1Rd, ci0Rd, sqRd}),
    .gate(gate), .statusRd(statusRd),
    .strb(strb), .status(status), .changeIrq(changeIrq),
    .pendValid(pendValid), .unread(unread)
  );

  ccd_chan_buf #(.W(SQ_W)) u_sq (
    .clk(clk), .rstN(rstN), .inCode(sqCode),
    .loadIn(strb.loadIn[CH_SQ]), .promote(strb.promote[CH_SQ]),
    .pendWrite(strb.pendWrite[CH_SQ]), .visCode(sqReg),
    .diffVis(diffVis[CH_SQ]), .diffPend(diffPend[CH_SQ])
  );

  ccd_chan_buf #(.W(CI0_W)) u_ci0 (
    .clk(clk), .rstN(rstN), .inCode(ci0Code),
    .loadIn(strb.loadIn[CH_CI0]), .promote(strb.promote[CH_CI0]),
    .pendWrite(strb.pendWrite[CH_CI0]), .visCode(ci0Reg),
    .diffVis(diffVis[CH_CI0]), .diffPend(diffPend[CH_CI0])
  );

  ccd_chan_buf #(.W(CI1_W)) u_ci1 (
    .clk(clk), .rstN(rstN), .inCode(ci1Code),
    .loadIn(strb.loadIn[CH_CI1]), .promote(strb.promote[CH_CI1]),
    .pendWrite(strb.pendWrite[CH_CI1]), .visCode(ci1Reg),
    .diffVis(diffVis[CH_CI1]), .diffPend(diffPend[CH_CI1])
  );
endmodule

// File: rtl/code_change_detect_chk.sv
module code_change_detect_chk #(
  parameter int CI0_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             ci0Valid,
  input logic             ci0Rd,
  input logic             statusRd,
  input logic             sqEnable,
  input logic             terminalMode,
  input logic [2:0]       status,
  input logic [CI0_W-1:0] ci0Reg,
  input logic             changeIrq,
  input logic [2:0]       pendValid,
  input logic [2:0]       unread
);
  // R1: reset state
  p_reset_state_r1: assert property (@(posedge clk)
    !rstN |=> (ci0Reg == '1 && status == 3'b000 && !changeIrq));

  // R4: unread visible register holds without a read
  p_hold_unread_r4: assert property (@(posedge clk) disable iff (!rstN)
    (unread[1] && !ci0Rd) |=> $stable(ci0Reg));

  // R5: read with waiting code re-raises flag and pulse
  p_promote_raise_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ci0Rd && pendValid[1]) |=> (status[1] && changeIrq));

  // R6: a waiting code only exists behind an unread register
  p_pend_needs_unread_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid & ~unread) == 3'b000);

  // R7: status read with no load clears the channel 0 flag
  p_status_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !ci0Valid && !ci0Rd) |=> !status[1]);

  // R8: masked S/Q flag never reported
  p_sq_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
    !sqEnable |-> !status[0]);

  // R9: channel 1 flag needs terminal mode
  p_ci1_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    !terminalMode |-> !status[2]);
endmodule

bind code_change_detect code_change_detect_chk #(.CI0_W(CI0_W)) u_chk (
  .clk(clk), .rstN(rstN), .ci0Valid(ci0Valid), .ci0Rd(ci0Rd),
  .statusRd(statusRd), .sqEnable(sqEnable), .terminalMode(terminalMode),
  .status(status), .ci0Reg(ci0Reg), .changeIrq(changeIrq),
  .pendValid(pendValid), .unread(unread)
);

// File: tb/code_change_detect_test.sv
module code_change_detect_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sqValid = 0, ci0Valid = 0, ci1Valid = 0;
  logic [3:0] sqCode = '0, ci0Code = '0;
  logic [5:0] ci1Code = '0;
  logic sqEnable = 1, ci1Enable = 1, terminalMode = 1;
  logic statusRd = 0, sqRd = 0, ci0Rd = 0, ci1Rd = 0;
  logic [2:0] status;
  logic [3:0] sqReg, ci0Reg;
  logic [5:0] ci1Reg;
  logic changeIrq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  code_change_detect uut (
    .clk(clk), .rstN(rstN),
    .sqValid(sqValid), .sqCode(sqCode),
    .ci0Valid(ci0Valid), .ci0Code(ci0Code),
    .ci1Valid(ci1Valid), .ci1Code(ci1Code),
    .sqEnable(sqEnable), .ci1Enable(ci1Enable), .terminalMode(terminalMode),
    .statusRd(statusRd), .sqRd(sqRd), .ci0Rd(ci0Rd), .ci1Rd(ci1Rd),
    .status(status), .sqReg(sqReg), .ci0Reg(ci0Reg), .ci1Reg(ci1Reg),
    .changeIrq(changeIrq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // advance one edge; outputs then reflect that edge
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic clearStrobes();
    sqValid = 0; ci0Valid = 0; ci1Valid = 0;
    statusRd = 0; sqRd = 0; ci0Rd = 0; ci1Rd = 0;
  endtask

  task automatic sendCi0(input logic [3:0] c);
    ci0Code = c; ci0Valid = 1; tick(); clearStrobes();
  endtask

  task automatic readStatus();
    statusRd = 1; tick(); clearStrobes();
  endtask

  task automatic testReset();
    chk("R1", "sqReg", sqReg, 4'hF);
    chk("R1", "ci0Reg", ci0Reg, 4'hF);
    chk("R1", "ci1Reg", ci1Reg, 6'h3F);
    chk("R1", "status", status, 0);
    chk("R1", "irq", changeIrq, 0);
  endtask

  task automatic testBasicLoad();
    sendCi0(4'h5);
    chk("R2", "ci0Reg", ci0Reg, 4'h5);
    chk("R2", "status", status, 3'b010);
    chk("R2", "irq", changeIrq, 1);
    tick();
    chk("R2", "irq one cycle", changeIrq, 0);
  endtask

  task automatic testClearAndIgnore();
    readStatus();
    chk("R7", "status cleared", status, 0);
    sendCi0(4'h5);
    chk("R3", "irq on same code", changeIrq, 0);
    chk("R3", "status on same code", status, 0);
    chk("R3", "ci0Reg", ci0Reg, 4'h5);
  endtask

  task automatic testHoldAndPromote();
    sendCi0(4'h9);
    chk("R4", "ci0Reg held", ci0Reg, 4'h5);
    chk("R4", "irq while held", changeIrq, 0);
    sendCi0(4'h3);
    sendCi0(4'h7);
    chk("R6", "ci0Reg still first", ci0Reg, 4'h5);
    chk("R6", "status while held", status, 0);
    ci0Rd = 1; tick(); clearStrobes();
    chk("R5", "promoted newest", ci0Reg, 4'h7);
    chk("R5", "flag re-raised", status, 3'b010);
    chk("R5", "irq re-raised", changeIrq, 1);
    readStatus();
    ci0Rd = 1; tick(); clearStrobes();
    chk("R10", "no pend read keeps reg", ci0Reg, 4'h7);
    chk("R10", "no irq", changeIrq, 0);
    sendCi0(4'h2);
    chk("R10", "direct load", ci0Reg, 4'h2);
    chk("R10", "irq", changeIrq, 1);
  endtask

  task automatic testCompareWithPending();
    readStatus();
    sendCi0(4'h8);          // held, visible 2
    sendCi0(4'h2);          // differs from waiting 8
    ci0Rd = 1; tick(); clearStrobes();
    chk("R6", "newest waiting shown", ci0Reg, 4'h2);
    chk("R6", "flag", status, 3'b010);
    ci0Rd = 1; tick(); clearStrobes();
  endtask

  task automatic testReadLoadSameCycle();
    readStatus();
    statusRd = 1; ci0Code = 4'hA; ci0Valid = 1; tick(); clearStrobes();
    chk("R7", "load beats clear", status, 3'b010);
    chk("R7", "ci0Reg", ci0Reg, 4'hA);
    readStatus();
    chk("R7", "cleared later", status, 0);
  endtask

  task automatic testSqMask();
    sqEnable = 0;
    sqCode = 4'h4; sqValid = 1; tick(); clearStrobes();
    chk("R8", "sqReg captured", sqReg, 4'h4);
    chk("R8", "masked flag", status, 0);
    chk("R8", "no irq", changeIrq, 0);
    sqEnable = 1; tick();
    chk("R8", "flag after enable", status, 3'b001);
    chk("R8", "irq after enable", changeIrq, 1);
    readStatus();
  endtask

  task automatic testCi1Gate();
    terminalMode = 0;
    ci1Code = 6'h15; ci1Valid = 1; tick(); clearStrobes();
    chk("R9", "ci1Reg captured", ci1Reg, 6'h15);
    chk("R9", "flag hidden", status, 0);
    chk("R9", "no irq", changeIrq, 0);
    terminalMode = 1; tick();
    chk("R9", "flag shown", status, 3'b100);
    chk("R9", "irq", changeIrq, 1);
    readStatus();
    ci1Rd = 1; tick(); clearStrobes();
    ci1Enable = 0;
    ci1Code = 6'h2A; ci1Valid = 1; tick(); clearStrobes();
    chk("R9", "ci1Reg loaded", ci1Reg, 6'h2A);
    chk("R9", "enable low hides", status, 0);
    chk("R9", "enable low no irq", changeIrq, 0);
    ci1Enable = 1;
  endtask

  initial begin
    #(CLK_PERIOD*2 + 3);
    testReset();
    rstN = 1;
    tick();
    testReset();
    testBasicLoad();
    testClearAndIgnore();
    testHoldAndPromote();
    testCompareWithPending();
    testReadLoadSameCycle();
    testSqMask();
    testCi1Gate();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*20000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule